// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block is a two-wire serial-bus slave that holds six 8-bit configuration registers for a clock synthesizer. The host can only transfer the whole bank as a block: a write sends a command byte and a length byte, which are both acknowledged and then discarded, followed by data bytes that fill the registers in ascending order from register 0. A read returns a length byte followed by the registers in the same ascending order.

Both bus lines are sampled in the system clock domain through synchronizers. The slave pulls SDA low by raising an output enable and never stretches the clock. The whole register bank is presented in parallel. Register 0 is also decoded into named control fields for the synthesizer. This interface carries no stream, so there is no valid/ready handshake. The register outputs are plain levels that change one byte at a time, as each written byte is acknowledged.

Top module: `cfg_i2c_slave`

## Requirements
- R1: After reset the registers hold, from register 0 upward: 0x00, 0xFF, 0xFF, 0x7F, 0x71, 0x00, and SDA is not driven.
- R2: The slave acknowledges only the address byte 0xD2 (write) or 0xD3 (read), that is, 7-bit address 0x69 followed by the R/W bit. For any other address it gives no acknowledge, acknowledges nothing else, and changes no register until the next start condition.
- R3: In a write, the first two bytes after the address (command and length) are each acknowledged and their values reach no register.
- R4: Data bytes in a write are each acknowledged and are stored in registers 0, 1, 2, … in the order they arrive.
- R5: A stop condition after any complete data byte ends the write. Every byte acknowledged before the stop is kept, and later registers keep their old values.
- R6: Data bytes after the sixth are still acknowledged and have no effect on any register.
- R7: A read returns the length byte 6, then registers 0 to 5 in order, and then 0xFF for every further byte the host acknowledges.
- R8: A host not-acknowledge after a read byte ends the transfer: the slave releases SDA, so bytes clocked afterwards read as 0xFF.
- R9: A stop or a repeated start in the middle of a byte discards that partial byte. After a repeated start, a new address byte is accepted.
- R10: The slave changes its SDA drive only while SCL is low.
- R11: Register 0 is decoded as follows: bits 7:4 are the frequency code, bit 3 selects register control of the frequency, bit 2 selects down spread (1) or center spread (0), bit 1 enables spread spectrum, and bit 0 turns the outputs off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level (wired-AND of all drivers) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| cfg_regs_o | output | 48 | Register bank, register n in bits 8n+7:8n |
| freq_code_o | output | 4 | Frequency code from register 0 |
| freq_by_reg_o | output | 1 | 1: frequency taken from the register rather than from the latched pins |
| spread_en_o | output | 1 | Spread spectrum enable |
| spread_down_o | output | 1 | 1: down spread, 0: center spread |
| outputs_off_o | output | 1 | Requests that all clock outputs be tristated |

## Verification
The hardest case to reach is a transfer that is broken off inside a byte, after some bits have already been shifted in but before the acknowledge. The bench has a bit-level host task, so it can issue a stop or a repeated start after any number of bits. It then confirms that the partial byte left the bank untouched and that a following read is accepted. Overrun in both directions (extra write bytes, and reads past register 5) is reached the same way, by clocking more bytes than the bank holds.

// File: rtl/cfgslv_pkg.sv
package cfgslv_pkg;

  localparam int CFG_NREG = 6;

  // Reset contents, register 0 in the low byte.
  localparam logic [CFG_NREG*8-1:0] CFG_RESET_VALUE =
    {8'h00, 8'h71, 8'h7F, 8'hFF, 8'hFF, 8'h00};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK
  } slv_state_e;

  // Field layout of register 0.
  typedef struct packed {
    logic [3:0] freq;
    logic       freq_by_reg;
    logic       spread_down;
    logic       spread_en;
    logic       outputs_off;
  } ctl0_t;

endpackage

// File: rtl/cfgslv_busmon.sv
module cfgslv_busmon #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_q,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int NLINES = 2;

  logic [NLINES-1:0] line_in, line_q, line_p;

  assign line_in = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], line_in[g]};
    end
    assign line_q[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) line_p <= '1;
    else        line_p <= line_q;
  end

  assign scl_q     = line_q[1];
  assign sda_q     = line_q[0];
  assign scl_rise  =  line_q[1] & ~line_p[1];
  assign scl_fall  = ~line_q[1] &  line_p[1];
  assign start_det =  line_q[1] &  line_p[1] &  line_p[0] & ~line_q[0];
  assign stop_det  =  line_q[1] &  line_p[1] & ~line_p[0] &  line_q[0];

endmodule

// File: rtl/cfgslv_proto.sv
module cfgslv_proto
  import cfgslv_pkg::*;
#(
  parameter int          NREG     = 6,
  parameter logic [6:0]  DEV_ADDR = 7'h69,
  parameter int          IDX_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_q,
  input  logic             sda_q,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [7:0]       rd_data,
  output logic [IDX_W-1:0] rd_idx,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic [7:0]       wr_data,
  output logic             sda_oe
);

  localparam logic [IDX_W-1:0] IDX_MAX   = IDX_W'(NREG + 2);
  localparam logic [IDX_W-1:0] IDX_FIRST = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(NREG);
  localparam logic [7:0]       LEN_BYTE  = 8'(NREG);

  slv_state_e       state;
  logic [2:0]       bitcnt;
  logic [7:0]       shreg;
  logic [IDX_W-1:0] byte_idx;
  logic             got8;
  logic             is_read;
  logic             host_ack;
  logic [7:0]       tx_byte;
  logic [IDX_W-1:0] idx_next;

  assign idx_next = (byte_idx == IDX_MAX) ? byte_idx : byte_idx + IDX_W'(1);
  assign rd_idx   = byte_idx - IDX_W'(1);
  assign wr_idx   = byte_idx - IDX_FIRST;
  assign wr_data  = shreg;

  always_comb begin
    if (byte_idx == '0)           tx_byte = LEN_BYTE;
    else if (byte_idx <= IDX_LAST) tx_byte = rd_data;
    else                          tx_byte = 8'hFF;
  end

  // Commit a data byte on the SCL fall that opens its acknowledge slot.
  assign wr_en = (state == ST_WR_BYTE) && scl_fall && got8 &&
                 (byte_idx >= IDX_FIRST) && (byte_idx < IDX_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      byte_idx <= '0;
      got8     <= 1'b0;
      is_read  <= 1'b0;
      host_ack <= 1'b0;
      sda_oe   <= 1'b0;
    end else if (start_det) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
      got8   <= 1'b0;
      sda_oe <= 1'b0;
    end else if (stop_det) begin
      state  <= ST_IDLE;
      got8   <= 1'b0;
      sda_oe <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: ;
        ST_ADDR, ST_WR_BYTE: begin
          if (scl_rise) begin
            shreg  <= {shreg[6:0], sda_q};
            bitcnt <= bitcnt + 3'd1;
            if (bitcnt == 3'd7) got8 <= 1'b1;
          end else if (scl_fall && got8) begin
            got8   <= 1'b0;
            bitcnt <= '0;
            if (state == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                sda_oe   <= 1'b1;
                is_read  <= shreg[0];
                byte_idx <= '0;
                state    <= ST_ADDR_ACK;
              end else begin
                state <= ST_IDLE;
              end
            end else begin
              sda_oe   <= 1'b1;
              byte_idx <= idx_next;
              state    <= ST_WR_ACK;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bitcnt <= '0;
            if (is_read) begin
              shreg  <= tx_byte;
              sda_oe <= ~tx_byte[7];
              state  <= ST_RD_BYTE;
            end else begin
              sda_oe <= 1'b0;
              state  <= ST_WR_BYTE;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            state  <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            if (bitcnt == 3'd7) begin
              sda_oe   <= 1'b0;
              byte_idx <= idx_next;
              state    <= ST_RD_ACK;
            end else begin
              bitcnt <= bitcnt + 3'd1;
              shreg  <= {shreg[6:0], 1'b1};
              sda_oe <= ~shreg[6];
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            host_ack <= ~sda_q;
          end else if (scl_fall) begin
            if (host_ack) begin
              bitcnt <= '0;
              shreg  <= tx_byte;
              sda_oe <= ~tx_byte[7];
              state  <= ST_RD_BYTE;
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: an unaddressed or finished slave leaves SDA alone.
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> !sda_oe);

  // R8: the host's acknowledge slot is never driven by the slave.
  a_r8_host_ack_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_RD_ACK) |-> !sda_oe);

  // R10: the drive changes only while the synchronized SCL is low.
  a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> !scl_q);

endmodule

// File: rtl/cfgslv_regbank.sv
module cfgslv_regbank #(
  parameter int                NREG  = 6,
  parameter int                IDX_W = 4,
  parameter logic [NREG*8-1:0] INIT  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [7:0]        wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [7:0]        rd_data,
  output logic [NREG*8-1:0] regs_flat
);

  logic [7:0] regs [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              regs[i] <= INIT[i*8 +: 8];
      else if (wr_en && wr_idx == IDX_W'(i))   regs[i] <= wr_data;
    end
    assign regs_flat[i*8 +: 8] = regs[i];
  end

  always_comb begin
    rd_data = 8'hFF;
    for (int i = 0; i < NREG; i++)
      if (rd_idx == IDX_W'(i)) rd_data = regs[i];
  end

  // R4: the bank changes only on a commit from the protocol engine.
  a_r4_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_flat));

  // R6: the protocol engine never commits past the last register.
  a_r6_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(NREG)));

endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfgslv_pkg::*;
#(
  parameter int                NREG        = CFG_NREG,
  parameter logic [6:0]        DEV_ADDR    = 7'h69,
  parameter int                SYNC_STAGES = 2,
  parameter logic [NREG*8-1:0] REG_INIT    = CFG_RESET_VALUE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  output logic [NREG*8-1:0] cfg_regs_o,
  output logic [3:0]        freq_code_o,
  output logic              freq_by_reg_o,
  output logic              spread_en_o,
  output logic              spread_down_o,
  output logic              outputs_off_o
);

  localparam int IDX_W = $clog2(NREG + 3);

  logic             scl_q, sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]       wr_data, rd_data;
  ctl0_t            ctl0;

  cfgslv_busmon #(.STAGES(SYNC_STAGES)) u_busmon (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  cfgslv_proto #(.NREG(NREG), .DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_proto (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_q     (scl_q),
    .sda_q     (sda_q),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .rd_idx    (rd_idx),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .sda_oe    (sda_oe_o)
  );

  cfgslv_regbank #(.NREG(NREG), .IDX_W(IDX_W), .INIT(REG_INIT)) u_regbank (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_idx    (rd_idx),
    .rd_data   (rd_data),
    .regs_flat (cfg_regs_o)
  );

  // R11: field decode of register 0.
  assign ctl0          = ctl0_t'(cfg_regs_o[7:0]);
  assign freq_code_o   = ctl0.freq;
  assign freq_by_reg_o = ctl0.freq_by_reg;
  assign spread_down_o = ctl0.spread_down;
  assign spread_en_o   = ctl0.spread_en;
  assign outputs_off_o = ctl0.outputs_off;

endmodule

// File: tb/cfg_i2c_slave_tb.sv
module cfg_i2c_slave_tb;

  localparam int Q = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        scl = 1'b1;
  logic        sda_h = 1'b1;
  wire         sda_bus;
  logic        sda_oe;
  logic [47:0] regs;
  logic [3:0]  freq_code;
  logic        freq_by_reg, spread_en, spread_down, outputs_off;

  int checks = 0;
  int failures = 0;
  int r10_viol = 0;
  bit done = 1'b0;
  logic [7:0] exp_r [6];
  logic       oe_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_bus = sda_h & ~sda_oe;

  cfg_i2c_slave u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .scl_i         (scl),
    .sda_i         (sda_bus),
    .sda_oe_o      (sda_oe),
    .cfg_regs_o    (regs),
    .freq_code_o   (freq_code),
    .freq_by_reg_o (freq_by_reg),
    .spread_en_o   (spread_en),
    .spread_down_o (spread_down),
    .outputs_off_o (outputs_off)
  );

  // R10 monitor: the slave drive must not move while the real SCL is high.
  always @(negedge clk) begin
    if (rst_n && scl && (sda_oe != oe_prev)) r10_viol++;
    oe_prev <= sda_oe;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
    end
  endtask

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_xfer(input logic b, output logic s);
    sda_h = b; hq();
    scl = 1'b1; hq();
    s = sda_bus; hq();
    scl = 1'b0; hq();
  endtask

  task automatic bus_start();
    sda_h = 1'b1; hq();
    scl = 1'b1; hq();
    sda_h = 1'b0; hq();
    scl = 1'b0; hq();
  endtask

  task automatic bus_stop();
    sda_h = 1'b0; hq();
    scl = 1'b1; hq();
    sda_h = 1'b1; hq();
  endtask

  task automatic wbyte(input logic [7:0] d, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_xfer(d[i], s);
    bit_xfer(1'b1, s);
    ack = ~s;
  endtask

  task automatic rbyte(output logic [7:0] d, input logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      bit_xfer(1'b1, s);
      d[i] = s;
    end
    bit_xfer(~ack, s);
  endtask

  function automatic logic [47:0] exp_flat();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = exp_r[i];
    return v;
  endfunction

  task automatic t_reset();
    exp_r[0] = 8'h00; exp_r[1] = 8'hFF; exp_r[2] = 8'hFF;
    exp_r[3] = 8'h7F; exp_r[4] = 8'h71; exp_r[5] = 8'h00;
    chk("R1", "reset bank", 64'(regs), 64'(exp_flat()));
    chk("R1", "reset sda drive", 64'(sda_oe), 64'd0);
    chk("R11", "reset decode", 64'({freq_code, freq_by_reg, spread_down, spread_en, outputs_off}), 64'd0);
  endtask

  task automatic t_full_write();
    logic a;
    logic [7:0] d [6] = '{8'hB6, 8'h12, 8'h34, 8'h56, 8'h78, 8'h9A};
    bus_start();
    wbyte(8'hD2, a); chk("R2", "write address ack", 64'(a), 64'd1);
    wbyte(8'hA5, a); chk("R3", "command ack", 64'(a), 64'd1);
    wbyte(8'h3C, a); chk("R3", "length ack", 64'(a), 64'd1);
    for (int i = 0; i < 6; i++) begin
      wbyte(d[i], a);
      chk("R4", $sformatf("data ack %0d", i), 64'(a), 64'd1);
      exp_r[i] = d[i];
    end
    bus_stop();
    chk("R4", "bank after full write", 64'(regs), 64'(exp_flat()));
    chk("R3", "command/length not stored in reg0", 64'(regs[7:0]), 64'hB6);
    // 0xB6 = 1011_0110: code B, pin select 0, down 1, spread 1, off 0
    chk("R11", "decoded fields", 64'({freq_code, freq_by_reg, spread_down, spread_en, outputs_off}),
        64'({4'hB, 1'b0, 1'b1, 1'b1, 1'b0}));
  endtask

  task automatic t_read_all();
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte(8'hD3, a); chk("R2", "read address ack", 64'(a), 64'd1);
    rbyte(d, 1'b1);  chk("R7", "length byte", 64'(d), 64'd6);
    for (int i = 0; i < 6; i++) begin
      rbyte(d, 1'b1);
      chk("R7", $sformatf("read reg %0d", i), 64'(d), 64'(exp_r[i]));
    end
    rbyte(d, 1'b0);  chk("R7", "byte past bank", 64'(d), 64'hFF);
    bus_stop();
  endtask

  task automatic t_short_write();
    logic a;
    bus_start();
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h06, a);
    wbyte(8'h11, a); wbyte(8'h22, a);
    bus_stop();
    exp_r[0] = 8'h11; exp_r[1] = 8'h22;
    chk("R5", "early stop keeps completed bytes only", 64'(regs), 64'(exp_flat()));
  endtask

  task automatic t_partial_byte();
    logic a, s;
    logic [7:0] d;
    bus_start();
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h00, a);
    wbyte(8'h33, a);
    for (int i = 0; i < 4; i++) bit_xfer(1'b0, s);
    bus_stop();
    exp_r[0] = 8'h33;
    chk("R9", "stop mid-byte discards partial byte", 64'(regs), 64'(exp_flat()));
    bus_start();
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h00, a);
    for (int i = 0; i < 3; i++) bit_xfer(1'b0, s);
    bus_start();
    wbyte(8'hD3, a); chk("R9", "address after repeated start", 64'(a), 64'd1);
    rbyte(d, 1'b1);  chk("R9", "length after repeated start", 64'(d), 64'd6);
    rbyte(d, 1'b0);  chk("R9", "reg0 unchanged by partial byte", 64'(d), 64'(exp_r[0]));
    bus_stop();
  endtask

  task automatic t_overrun();
    logic a;
    bus_start();
    wbyte(8'hD2, a); wbyte(8'h00, a); wbyte(8'h00, a);
    for (int i = 0; i < 8; i++) begin
      wbyte(8'h40 + 8'(i), a);
      if (i >= 6) chk("R6", $sformatf("extra byte %0d ack", i), 64'(a), 64'd1);
      if (i < 6) exp_r[i] = 8'h40 + 8'(i);
    end
    bus_stop();
    chk("R6", "extra bytes ignored", 64'(regs), 64'(exp_flat()));
  endtask

  task automatic t_wrong_addr();
    logic a;
    bus_start();
    wbyte(8'hA2, a); chk("R2", "foreign write address not acked", 64'(a), 64'd0);
    wbyte(8'h00, a); chk("R2", "following byte not acked", 64'(a), 64'd0);
    wbyte(8'hEE, a);
    bus_stop();
    bus_start();
    wbyte(8'hD1, a); chk("R2", "neighbour address not acked", 64'(a), 64'd0);
    bus_stop();
    chk("R2", "bank untouched by foreign transfer", 64'(regs), 64'(exp_flat()));
  endtask

  task automatic t_nack_read();
    logic a;
    logic [7:0] d;
    bus_start();
    wbyte(8'hD3, a);
    rbyte(d, 1'b1); chk("R8", "length before nack", 64'(d), 64'd6);
    rbyte(d, 1'b0); chk("R8", "reg0 before nack", 64'(d), 64'(exp_r[0]));
    rbyte(d, 1'b0); chk("R8", "bus released after nack", 64'(d), 64'hFF);
    bus_stop();
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_full_write();
    t_read_all();
    t_short_write();
    t_partial_byte();
    t_overrun();
    t_read_all();
    t_wrong_addr();
    t_nack_read();
    chk("R10", "drive changes while SCL high", 64'(r10_viol), 64'd0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule